// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block turns a supply-good flag and a pushbutton-style manual-reset request into the reset for a processor. It drives the reset as two outputs, one active-low and one active-high. The two always carry opposite values. Reset is asserted as long as the supply flag reports a low supply or the manual request is held. Once both requests go away, reset stays asserted for a further `RESET_CYCLES` clock cycles and is then released.

Both request inputs come from outside the clock domain, so each passes through its own two-flop synchronizer before it is used. Any new request restarts the full hold time, including one that arrives while a pulse is already counting down. Because of this, a short supply dip or a bouncing pushbutton yields one clean pulse of at least the full width. The full width acts as the debounce.

A synchronous power-on initialisation input puts the block into the asserted state. The nominal hold time is about 200 ms, written as a cycle count.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_ok` is low, `reset` stays 1 on every cycle, however long the low lasts.
- R2: After all requests clear, reset stays asserted for exactly `RESET_CYCLES` cycles, counted from the first quiet cycle at the synchronizer output. The latency from an input pin change to the output is the two synchronizer stages plus one output register. So, seen from a release driven at a falling clock edge, `reset` is sampled 1 at exactly `RESET_CYCLES`+2 successive falling edges and is 0 at the next one.
- R3: When `supply_ok` drops while reset is released, `reset` is 1 no later than the fourth falling clock edge after the drop.
- R4: A supply dip during a pulse that is already counting down restarts the count. After the dip ends, reset lasts the full R2 length again.
- R5: `reset` is always the exact complement of `reset_n`.
- R6: Holding `man_rst_n` low (0 = request) keeps reset asserted for the whole time it is held. Releasing it is followed by the full R2 hold.
- R7: A `man_rst_n` that bounces, with a single-cycle low, a return high and another low, produces one unbroken pulse. The pulse ends the full R2 length after the last low.
- R8: A low on `por_n` (0 = initialise) asserts reset from the next clock edge. The synchronizers restart in the "supply bad" state, so releasing `por_n` with the supply good is followed by the full R2 hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on initialisation, active low |
| supply_ok | input | 1 | Asynchronous supply-good flag from an external comparator, 1 = good |
| man_rst_n | input | 1 | Asynchronous manual-reset request, active low |
| reset_n | output | 1 | Processor reset, active low, registered |
| reset | output | 1 | Processor reset, active high, registered complement of `reset_n` |

## Verification
Four properties are checked on every cycle:
- the two outputs are complementary;
- a synchronized request shows up as asserted reset two cycles later;
- a release happens only after at least `RESET_CYCLES` quiet cycles, counted by a saturating counter in the checker;
- initialisation forces reset.

The exact pulse lengths can only be shown by the directed scenarios, which count falling edges from a pin change. These scenarios are:
- the restart of a pulse already counting down;
- a bouncing button giving a single pulse;
- the latency of a brownout.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Phase of the reset pulse timer.
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,  // a request is active, counter held at full value
    PH_COUNT = 2'd1,  // requests clear, counting down
    PH_RUN   = 2'd2   // reset released
  } phase_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!por_n) chain[0] <= RST_VAL;
        else        chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!por_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/supv_timer.sv
module supv_timer
  import supv_pkg::*;
#(
  parameter int unsigned RESET_CYCLES = 50_000_000,
  localparam int unsigned CW = $clog2(RESET_CYCLES + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic req,
  output logic hold_rst
);

  localparam logic [CW-1:0] FULL = CW'(RESET_CYCLES);

  phase_e        phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      phase <= PH_HOLD;
      cnt   <= FULL;
    end else if (req) begin
      phase <= PH_HOLD;
      cnt   <= FULL;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      phase <= (cnt == CW'(1)) ? PH_RUN : PH_COUNT;
    end else begin
      phase <= PH_RUN;
    end
  end

  assign hold_rst = (phase != PH_RUN);

endmodule

// File: rtl/supv_out.sv
module supv_out (
  input  logic clk,
  input  logic por_n,
  input  logic hold_rst,
  output logic rst_n_q,
  output logic rst_q
);

  // Two separate flops so that each pad gets its own clean registered drive.
  always_ff @(posedge clk) begin
    if (!por_n) begin
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      rst_n_q <= ~hold_rst;
      rst_q   <= hold_rst;
    end
  end

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned RESET_CYCLES = 50_000_000,
  parameter int unsigned SYNC_STAGES  = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic man_rst_n,
  output logic reset_n,
  output logic reset
);

  logic sup_s;
  logic mr_s;
  logic req_s;
  logic hold_rst;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
    .clk(clk), .por_n(por_n), .din(supply_ok), .dout(sup_s)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mr (
    .clk(clk), .por_n(por_n), .din(man_rst_n), .dout(mr_s)
  );

  assign req_s = ~sup_s | ~mr_s;

  supv_timer #(.RESET_CYCLES(RESET_CYCLES)) u_timer (
    .clk(clk), .por_n(por_n), .req(req_s), .hold_rst(hold_rst)
  );

  supv_out u_out (
    .clk(clk), .por_n(por_n), .hold_rst(hold_rst),
    .rst_n_q(reset_n), .rst_q(reset)
  );

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int unsigned RESET_CYCLES = 50_000_000,
  localparam int unsigned QW = $clog2(RESET_CYCLES + 2) + 1
) (
  input logic clk,
  input logic por_n,
  input logic req,
  input logic reset_n,
  input logic reset
);

  localparam logic [QW-1:0] QMAX = QW'(RESET_CYCLES + 1);

  // Quiet cycles seen since the last synchronized request (saturating).
  logic [QW-1:0] qcnt;

  always_ff @(posedge clk) begin
    if (!por_n || req) qcnt <= '0;
    else if (qcnt != QMAX) qcnt <= qcnt + 1'b1;
  end

  p_complement_r5: assert property (@(posedge clk) disable iff (!por_n)
    reset == !reset_n);

  p_req_holds_r1: assert property (@(posedge clk) disable iff (!por_n)
    req |-> ##2 reset);

  p_min_quiet_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reset_n) |-> (qcnt >= QW'(RESET_CYCLES)));

  p_por_forces_r8: assert property (@(posedge clk)
    !por_n |=> reset);

endmodule

bind supv_reset_gen supv_reset_chk #(.RESET_CYCLES(RESET_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .req(req_s), .reset_n(reset_n), .reset(reset)
);

// File: tb/sim_supv_reset_gen.sv
`timescale 1ns/1ps
module sim_supv_reset_gen;

  localparam int unsigned N = 20;
  localparam int EXP_W = N + 2;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_ok = 1'b1;
  logic man_rst_n = 1'b1;
  logic reset_n;
  logic reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supv_reset_gen #(.RESET_CYCLES(N)) u0 (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
    .reset_n(reset_n), .reset(reset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts falling edges with reset high; flags any cycle where outputs disagree.
  task automatic measure(output int width, output int mism);
    width = 0;
    mism = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (reset == reset_n) mism++;
      if (reset) width++;
      else break;
    end
  endtask

  task automatic wait_released();
    int w, m;
    measure(w, m);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_power_on();
    int w, m;
    @(negedge clk);
    check(reset == 1'b1 && reset_n == 1'b0, "R8 init state", reset, 1);
    por_n = 1'b1;
    measure(w, m);
    check(w == EXP_W, "R8 pulse after init", w, EXP_W);
    check(m == 0, "R5 complement during init pulse", m, 0);
    @(negedge clk);
    check(reset == 1'b0 && reset_n == 1'b1, "R5 released levels", reset, 0);
  endtask

  task automatic t_brownout_latency();
    int seen = 0;
    supply_ok = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (reset && seen == 0) seen = i;
    end
    check(seen != 0 && seen <= 4, "R3 brownout latency", seen, 4);
  endtask

  task automatic t_sustained_low();
    int w, m, high = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (reset) high++;
    end
    check(high == 100, "R1 held while supply low", high, 100);
    supply_ok = 1'b1;
    measure(w, m);
    check(w == EXP_W, "R2 release width", w, EXP_W);
    check(m == 0, "R5 complement", m, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_dip_mid_pulse();
    int w, m;
    supply_ok = 1'b0;
    repeat (6) @(negedge clk);
    supply_ok = 1'b1;
    repeat (8) @(negedge clk);
    check(reset == 1'b1, "R4 still counting before dip", reset, 1);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    check(reset == 1'b1, "R4 asserted during dip", reset, 1);
    supply_ok = 1'b1;
    measure(w, m);
    check(w == EXP_W, "R4 restarted width", w, EXP_W);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_manual_hold();
    int w, m, high = 0;
    man_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (reset) high++;
    end
    check(high == 60, "R6 held while button low", high, 60);
    man_rst_n = 1'b1;
    measure(w, m);
    check(w == EXP_W, "R6 width after button release", w, EXP_W);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_bounce();
    int w, m;
    check(reset == 1'b0, "R7 idle before bounce", reset, 0);
    man_rst_n = 1'b0;
    @(negedge clk);
    man_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    man_rst_n = 1'b0;
    @(negedge clk);
    man_rst_n = 1'b1;
    measure(w, m);
    check(w == EXP_W, "R7 single pulse after bounce", w, EXP_W);
    repeat (5) @(negedge clk);
    check(reset == 1'b0, "R7 no second pulse", reset, 0);
  endtask

  task automatic t_short_glitch();
    int w, m;
    man_rst_n = 1'b0;
    @(negedge clk);
    man_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(reset == 1'b1, "R6 one-cycle press triggers pulse", reset, 1);
    wait_released();
    check(reset == 1'b0, "R6 released after glitch pulse", reset, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_power_on();
    t_brownout_latency();
    t_sustained_low();
    t_dip_mid_pulse();
    t_manual_hold();
    t_bounce();
    t_short_glitch();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule